// File: doc/BRIEF.md
# Set-Associative Tag Cache with Selectable Store-Miss Allocation

This block is a tag-only model of a data cache. It takes a stream of load and store requests, each carrying a byte address. It splits every address into a line offset, a set index and a tag, and compares the tag against all ways of the selected set. It returns a hit or miss verdict one cycle after a request is accepted. No data is stored. The block tracks only which lines are resident and how recently each was used, so it can measure hit rates or steer a separate data path.

Each set keeps a full least-recently-used ordering. On a miss that allocates, an empty way is filled first. When the set is full, the oldest way is replaced. A mode input picks what happens on a store miss:
- With allocation, the store miss places the line in the cache.
- Without allocation, the store miss leaves the set, including its ordering, exactly as it was, and is reported as a write-through to memory.

Two running counters tally hits and misses. The geometry is set by parameters: total capacity, line size and way count. One way gives a direct-mapped cache.

Top module: `sa_tag_cache`

## Requirements
- R1: With 32-byte lines, address bits [4:0] are the line offset. The next log2(sets) bits are the set index and the remaining upper bits are the tag, where sets = capacity / (32 × ways). Two addresses that differ only in the offset refer to the same line.
- R2: After reset no line is resident, `rsp_valid` is 0, and both counters are 0. A line that was resident before a reset misses after it.
- R3: `req_ready` is 1 from the first clock after reset. A request accepted at a clock edge has its response, with `rsp_valid` = 1, in the following cycle.
- R4: A load or store to a resident line reports `rsp_hit` = 1 and makes that way the most recently used.
- R5: An allocating miss fills an empty way of the set when one exists. Lines brought into a set up to its way count all remain resident.
- R6: When a full set takes an allocating miss, the least recently used way is replaced. The new line becomes the most recently used, and every other way ages by one position.
- R7: With `no_alloc` = 1, a store miss reports `rsp_hit` = 0 and `rsp_write_through` = 1. It leaves the tags, valid bits and recency order of the set unchanged.
- R8: With `no_alloc` = 0, a store miss allocates the line like a load miss and reports `rsp_write_through` = 0.
- R9: With `no_alloc` = 1, a store hit reports a hit with `rsp_write_through` = 0 and refreshes the recency order like any hit.
- R10: `hit_count` and `miss_count` each rise by exactly one for every response that is a hit or a miss respectively, and stay still otherwise.
- R11: With one way, the cache is direct-mapped. A second line that maps to the same set replaces the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The cache accepts a request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the request |
| no_alloc | input | 1 | 1 = store misses do not allocate |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | The request hit |
| rsp_store | output | 1 | The response belongs to a store |
| rsp_write_through | output | 1 | A store miss that bypassed the cache |
| hit_count | output | CNT_W | Running count of hits |
| miss_count | output | CNT_W | Running count of misses |

## Verification
The bench builds two copies of the block.

The first is a 16 KB, four-way cache with 128 sets. Four ways is few enough that a directed sequence can fill a set, reorder it with hits and predict the exact victim. It also lets the bench show that a no-allocate store miss leaves that order intact. Each scenario uses its own set index so the scenarios do not disturb one another.

The second is a 1 KB, one-way copy with 32 sets. It reaches the direct-mapped corner, where the recency logic collapses to a single way and every conflicting tag evicts.

// File: rtl/cache_cfg_pkg.sv
package cache_cfg_pkg;

  // Width of a field able to name n items; never less than one bit.
  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Number of sets for a given geometry.
  function automatic int set_total(input int cap, input int line, input int ways);
    return cap / (line * ways);
  endfunction

endpackage

// File: rtl/cache_way_match.sv
module cache_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int WAY_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         check_en,
  input  logic [WAYS-1:0]              way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
  input  logic [TAG_W-1:0]             look_tag,
  output logic [WAYS-1:0]              match_vec,
  output logic                         any_match,
  output logic [WAY_W-1:0]             match_way
);

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign match_vec[g] = way_valid[g] && (way_tag[g] == look_tag);
    end
  endgenerate

  assign any_match = |match_vec;

  always_comb begin
    match_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match_vec[i]) match_way = WAY_W'(i);
    end
  end

  // R5: a line is never resident in two ways of one set
  p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    check_en |-> $onehot0(match_vec));

endmodule

// File: rtl/cache_lru_order.sv
module cache_lru_order #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][WAY_W-1:0] age_in,
  input  logic [WAY_W-1:0]           touch_way,
  output logic [WAYS-1:0][WAY_W-1:0] age_out,
  output logic [WAYS-1:0]            oldest_mark,
  output logic [WAY_W-1:0]           victim_way
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // Age 0 is most recent; OLDEST marks the replacement candidate.
  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      oldest_mark[i] = (age_in[i] == OLDEST);
    end
  end

  always_comb begin
    victim_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (oldest_mark[i]) victim_way = WAY_W'(i);
    end
  end

  // Touched way becomes youngest; those younger than it step back one place.
  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == touch_way)
        age_out[i] = '0;
      else if (age_in[i] < age_in[touch_way])
        age_out[i] = age_in[i] + WAY_W'(1);
      else
        age_out[i] = age_in[i];
    end
  end

endmodule

// File: rtl/cache_fill_pick.sv
module cache_fill_pick #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  way_valid,
  input  logic [WAY_W-1:0] victim_way,
  output logic             has_empty,
  output logic [WAY_W-1:0] fill_way
);

  logic [WAY_W-1:0] empty_way;

  // Lowest-numbered empty way wins.
  always_comb begin
    empty_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_valid[i]) empty_way = WAY_W'(i);
    end
  end

  assign has_empty = ~&way_valid;
  assign fill_way  = has_empty ? empty_way : victim_way;

endmodule

// File: rtl/sa_tag_cache.sv
module sa_tag_cache
  import cache_cfg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CAPACITY   = 16384,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 4,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              no_alloc,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_store,
  output logic              rsp_write_through,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  localparam int SETS  = set_total(CAPACITY, LINE_BYTES, WAYS);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = bits_for(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = bits_for(WAYS);

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return IDX_W'(a >> OFF_W);
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return TAG_W'(a >> (OFF_W + IDX_W));
  endfunction

  // Per-set state
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0]            valid_q;
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;

  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] look_tag;
  assign set_idx  = set_of(req_addr);
  assign look_tag = tag_of(req_addr);

  logic [WAYS-1:0]            valid_cur;
  logic [WAYS-1:0][TAG_W-1:0] tag_cur;
  logic [WAYS-1:0][WAY_W-1:0] age_cur;
  assign valid_cur = valid_q[set_idx];
  assign tag_cur   = tag_q[set_idx];
  assign age_cur   = age_q[set_idx];

  // Named internal events
  logic             ev_accept;
  logic             ev_hit;
  logic             ev_alloc;
  logic             ev_bypass;
  logic             ev_update;
  logic [WAYS-1:0]  match_vec;
  logic [WAY_W-1:0] match_way;
  logic [WAY_W-1:0] victim_way;
  logic [WAY_W-1:0] fill_way;
  logic [WAY_W-1:0] touch_way;
  logic [WAYS-1:0]  oldest_mark;
  logic             has_empty;
  logic [WAYS-1:0][WAY_W-1:0] age_next;

  cache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .check_en  (ev_accept),
    .way_valid (valid_cur),
    .way_tag   (tag_cur),
    .look_tag  (look_tag),
    .match_vec (match_vec),
    .any_match (ev_hit),
    .match_way (match_way)
  );

  cache_lru_order #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
    .age_in      (age_cur),
    .touch_way   (touch_way),
    .age_out     (age_next),
    .oldest_mark (oldest_mark),
    .victim_way  (victim_way)
  );

  cache_fill_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_fill (
    .way_valid  (valid_cur),
    .victim_way (victim_way),
    .has_empty  (has_empty),
    .fill_way   (fill_way)
  );

  assign ev_accept = req_valid && req_ready;
  assign ev_bypass = ev_accept && !ev_hit && req_store && no_alloc;
  assign ev_alloc  = ev_accept && !ev_hit && !(req_store && no_alloc);
  assign ev_update = (ev_accept && ev_hit) || ev_alloc;
  assign touch_way = ev_hit ? match_way : fill_way;

  // Ready rises one clock after reset is released.
  always_ff @(posedge clk) begin
    if (!rst_n) req_ready <= 1'b0;
    else        req_ready <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
          age_q[s][w]   <= WAY_W'(w);
        end
      end
    end else if (ev_update) begin
      age_q[set_idx] <= age_next;
      if (ev_alloc) begin
        valid_q[set_idx][fill_way] <= 1'b1;
        tag_q[set_idx][fill_way]   <= look_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid         <= 1'b0;
      rsp_hit           <= 1'b0;
      rsp_store         <= 1'b0;
      rsp_write_through <= 1'b0;
      hit_count         <= '0;
      miss_count        <= '0;
    end else begin
      rsp_valid         <= ev_accept;
      rsp_hit           <= ev_accept && ev_hit;
      rsp_store         <= ev_accept && req_store;
      rsp_write_through <= ev_bypass;
      if (ev_accept && ev_hit)  hit_count  <= hit_count + CNT_W'(1);
      if (ev_accept && !ev_hit) miss_count <= miss_count + CNT_W'(1);
    end
  end

  // R3: response follows acceptance by exactly one cycle
  p_rsp_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(ev_accept));

  // R6: the addressed set always has exactly one oldest way
  p_one_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> $countones(oldest_mark) == 1);

  // R5: an allocation never overwrites a live way while an empty one exists
  p_fill_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_alloc && has_empty) |-> !valid_cur[fill_way]);

  // R7: a bypassing store miss leaves every piece of set state unchanged
  p_bypass_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bypass |=> ($stable(age_q) && $stable(valid_q) && $stable(tag_q)));

  // R7: write-through is only flagged for a store that missed
  p_wt_store_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_write_through |-> (rsp_store && !rsp_hit && rsp_valid));

  // R10: counters advance by the response outcome only
  p_hit_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count - $past(hit_count)) == CNT_W'(rsp_valid && rsp_hit));

  p_miss_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count - $past(miss_count)) == CNT_W'(rsp_valid && !rsp_hit));

endmodule

// File: tb/sa_tag_cache_test.sv
`timescale 1ns/1ps
module sa_tag_cache_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  // Main instance: 16 KB, 4 ways, 128 sets -> index [11:5], tag [31:12]
  logic        m_valid = 1'b0, m_store = 1'b0, m_na = 1'b0;
  logic [31:0] m_addr = '0;
  logic        m_ready, m_rv, m_hit, m_rst, m_wt;
  logic [31:0] m_hc, m_mc;

  // Direct-mapped instance: 1 KB, 1 way, 32 sets -> index [9:5], tag [31:10]
  logic        d_valid = 1'b0, d_store = 1'b0, d_na = 1'b0;
  logic [31:0] d_addr = '0;
  logic        d_ready, d_rv, d_hit, d_rst, d_wt;
  logic [31:0] d_hc, d_mc;

  sa_tag_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(m_valid), .req_ready(m_ready),
    .req_store(m_store), .req_addr(m_addr), .no_alloc(m_na),
    .rsp_valid(m_rv), .rsp_hit(m_hit), .rsp_store(m_rst),
    .rsp_write_through(m_wt), .hit_count(m_hc), .miss_count(m_mc));

  sa_tag_cache #(.CAPACITY(1024), .WAYS(1)) uut_dm (
    .clk(clk), .rst_n(rst_n), .req_valid(d_valid), .req_ready(d_ready),
    .req_store(d_store), .req_addr(d_addr), .no_alloc(d_na),
    .rsp_valid(d_rv), .rsp_hit(d_hit), .rsp_store(d_rst),
    .rsp_write_through(d_wt), .hit_count(d_hc), .miss_count(d_mc));

  int checks = 0;
  int fails  = 0;
  int m_eh = 0, m_em = 0, d_eh = 0, d_em = 0;
  bit done = 1'b0;

  function automatic logic [31:0] maddr(input int tag, input int set, input int off);
    return 32'(tag * 4096 + set * 32 + off);
  endfunction

  function automatic logic [31:0] daddr(input int tag, input int set, input int off);
    return 32'(tag * 1024 + set * 32 + off);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_eh = 0; m_em = 0; d_eh = 0; d_em = 0;
    @(negedge clk);
  endtask

  // One request; the response is sampled one cycle after the accepting edge.
  task automatic req(input bit dm, input bit st, input logic [31:0] a, input bit na,
                     input bit eh, input bit ewt, input string rq);
    @(negedge clk);
    if (dm) begin
      check(d_ready == 1'b1, "R3", "dm ready", d_ready, 1);
      d_valid = 1'b1; d_store = st; d_addr = a; d_na = na;
    end else begin
      check(m_ready == 1'b1, "R3", "ready", m_ready, 1);
      m_valid = 1'b1; m_store = st; m_addr = a; m_na = na;
    end
    @(negedge clk);
    d_valid = 1'b0; m_valid = 1'b0;
    if (dm) begin
      check(d_rv == 1'b1, "R3", "dm rsp_valid", d_rv, 1);
      check(d_hit == eh, rq, "dm hit", d_hit, eh);
      check(d_wt == ewt, rq, "dm write_through", d_wt, ewt);
      if (eh) d_eh++; else d_em++;
    end else begin
      check(m_rv == 1'b1, "R3", "rsp_valid", m_rv, 1);
      check(m_hit == eh, rq, "hit", m_hit, eh);
      check(m_wt == ewt, rq, "write_through", m_wt, ewt);
      check(m_rst == st, rq, "rsp_store", m_rst, st);
      if (eh) m_eh++; else m_em++;
    end
  endtask

  task automatic t_reset_state();
    check(m_rv == 1'b0, "R2", "rsp_valid after reset", m_rv, 0);
    check(m_hc == 0, "R2", "hit_count after reset", m_hc, 0);
    check(m_mc == 0, "R2", "miss_count after reset", m_mc, 0);
    check(m_ready == 1'b1, "R3", "ready after reset", m_ready, 1);
  endtask

  task automatic t_split_r1();
    req(0, 0, maddr(5, 0, 0), 0, 0, 0, "R1");
    req(0, 0, maddr(5, 0, 31), 0, 1, 0, "R1");   // same line, other offset
    req(0, 0, maddr(5, 1, 0), 0, 0, 0, "R1");    // same tag, next set
    req(0, 1, maddr(5, 0, 17), 0, 1, 0, "R4");   // store hit
  endtask

  task automatic t_fill_r5();
    for (int t = 1; t <= 4; t++) req(0, 0, maddr(t, 4, 0), 0, 0, 0, "R5");
    for (int t = 1; t <= 4; t++) req(0, 0, maddr(t, 4, 8), 0, 1, 0, "R5");
  endtask

  task automatic t_lru_r6();
    for (int t = 1; t <= 4; t++) req(0, 0, maddr(t, 8, 0), 0, 0, 0, "R6");
    req(0, 0, maddr(1, 8, 0), 0, 1, 0, "R4");    // order now 1,4,3,2
    req(0, 0, maddr(5, 8, 0), 0, 0, 0, "R6");    // evicts 2
    req(0, 0, maddr(1, 8, 0), 0, 1, 0, "R6");
    req(0, 0, maddr(4, 8, 0), 0, 1, 0, "R6");
    req(0, 0, maddr(2, 8, 0), 0, 0, 0, "R6");    // evicts 3
    req(0, 0, maddr(3, 8, 0), 0, 0, 0, "R6");    // evicts 5
    req(0, 0, maddr(5, 8, 0), 0, 0, 0, "R6");
  endtask

  task automatic t_noalloc_r7();
    for (int t = 1; t <= 4; t++) req(0, 0, maddr(t, 9, 0), 1, 0, 0, "R7");
    req(0, 0, maddr(1, 9, 0), 1, 1, 0, "R4");    // order 1,4,3,2
    req(0, 1, maddr(9, 9, 0), 1, 0, 1, "R7");    // bypass
    req(0, 0, maddr(9, 9, 0), 1, 0, 0, "R7");    // not resident; evicts 2
    req(0, 0, maddr(3, 9, 0), 1, 1, 0, "R7");    // 3 survived
    req(0, 0, maddr(2, 9, 0), 1, 0, 0, "R7");    // evicts 4
    req(0, 0, maddr(4, 9, 0), 1, 0, 0, "R7");
    req(0, 1, maddr(3, 9, 4), 1, 1, 0, "R9");    // store hit, no write-through
  endtask

  task automatic t_walloc_r8();
    req(0, 1, maddr(7, 10, 0), 0, 0, 0, "R8");
    req(0, 0, maddr(7, 10, 12), 0, 1, 0, "R8");
  endtask

  task automatic t_counters_r10();
    @(negedge clk);
    check(m_hc == 32'(m_eh), "R10", "hit_count", m_hc, m_eh);
    check(m_mc == 32'(m_em), "R10", "miss_count", m_mc, m_em);
    check(d_hc == 32'(d_eh), "R10", "dm hit_count", d_hc, d_eh);
    check(d_mc == 32'(d_em), "R10", "dm miss_count", d_mc, d_em);
  endtask

  task automatic t_direct_r11();
    req(1, 0, daddr(3, 6, 0), 0, 0, 0, "R11");
    req(1, 0, daddr(3, 6, 4), 0, 1, 0, "R11");
    req(1, 0, daddr(4, 6, 0), 0, 0, 0, "R11");
    req(1, 0, daddr(3, 6, 0), 0, 0, 0, "R11");
    req(1, 1, daddr(8, 7, 0), 1, 0, 1, "R11");
    req(1, 0, daddr(3, 6, 0), 0, 1, 0, "R11");
  endtask

  task automatic t_reset_clears_r2();
    req(0, 0, maddr(11, 20, 0), 0, 0, 0, "R2");
    req(0, 0, maddr(11, 20, 0), 0, 1, 0, "R2");
    do_reset();
    t_reset_state();
    req(0, 0, maddr(11, 20, 0), 0, 0, 0, "R2");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_split_r1();
    t_fill_r5();
    t_lru_r6();
    t_noalloc_r7();
    t_walloc_r8();
    t_direct_r11();
    t_counters_r10();
    t_reset_clears_r2();
    t_counters_r10();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R3", "watchdog expired", 0, 1);
      finish_run();
    end
  end

endmodule